// File: doc/BRIEF.md
# Affine INT8 Requantization Unit

This block sits after an 8-bit multiply-accumulate array. It turns the signed 32-bit accumulator sums into 8-bit codes. Each accepted item carries an accumulator value, a channel index and a mode. The block processes the item in four steps:

1. It multiplies the value by that channel's unsigned fixed-point multiplier.
2. It divides by a power of two, rounding half away from zero.
3. It adds the channel's zero point.
4. It saturates the sum to the range of the selected output type.

Saturation happens after the zero point is added.

Per-channel multiplier, shift and zero point live in a small register file that loads through a one-cycle write port. The pipeline has three stages. It uses a valid/ready handshake on both sides and accepts one item per cycle while the consumer keeps up. A per-channel sticky flag records that clamping has occurred for that channel.

A separate dequantize path takes an 8-bit code, a channel and a mode. One cycle later it returns the difference between the code and the zero point, multiplied by the channel multiplier. The result is a fixed-point value whose binary point sits at the channel shift.

Top module: `requant_unit`

## Requirements
- R1: An item is taken on a rising edge where inValid and inReady are both high. Its result is loaded into outCode/outValid on the third rising edge counting the accepting edge, provided outReady stays high. While outValid is high and outReady is low, outValid stays high and outCode keeps its value.
- R2: With outReady held high, inReady stays high. Back-to-back items are accepted one per cycle and come out in acceptance order.
- R3: The result is the product acc*M of the signed accumulator and the unsigned 32-bit multiplier, divided by 2^sh (sh = 0..63) and rounded to nearest with halves rounded away from zero. The zero point Z is then added and the sum is clamped. Saturation is applied only to the sum that includes Z.
- R4: Mode 0 (signed asymmetric) reads Z as a signed 8-bit value and clamps to -128..127. The code is two's complement.
- R5: Mode 1 (unsigned asymmetric) reads Z as an unsigned 8-bit value and clamps to 0..255.
- R6: Modes 2 and 3 (symmetric) ignore the stored Z, using 0 in its place, and clamp to -127..127. Code 8'h80 is never produced in these modes.
- R7: An accumulator of 0 yields exactly the zero-point code: Z in modes 0 and 1, and 8'h00 in modes 2 and 3.
- R8: M, sh and Z are chosen by the channel index that travels with each item. A write with cfgWe high on an edge updates channel cfgChan. The write affects items accepted on later edges.
- R9: Bit c of satFlags is set when a clamped result of channel c is loaded into outCode. It stays set until reset or a configuration write to channel c.
- R10: dqValue, one edge after dqCode/dqChan/dqMode are applied, equals (code - Zeff)*M of that channel. Here code is read unsigned in mode 1 and signed otherwise. Zeff is Z read the same way, or 0 in modes 2 and 3.
- R11: After reset, outValid is low, inReady is high, satFlags is all zero and every channel's configuration is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input item valid |
| inReady | output | 1 | Block can take an input item |
| inAcc | input | 32 | Signed accumulator value |
| inChan | input | 3 | Channel index of the item |
| inMode | input | 2 | Output mode: 0 signed, 1 unsigned, 2/3 symmetric |
| outValid | output | 1 | Output code valid |
| outReady | input | 1 | Consumer takes the output code |
| outCode | output | 8 | Quantized output code |
| satFlags | output | 8 | Sticky per-channel saturation flags |
| cfgWe | input | 1 | Configuration write strobe |
| cfgChan | input | 3 | Channel to configure |
| cfgMult | input | 32 | Unsigned fixed-point multiplier |
| cfgShift | input | 6 | Right shift amount |
| cfgZero | input | 8 | Zero-point code |
| dqCode | input | 8 | Code to dequantize |
| dqChan | input | 3 | Channel for dequantization |
| dqMode | input | 2 | Mode in which dqCode is read |
| dqValue | output | 43 | Signed scaled difference (code - Z)*M |

## Verification
The hardest situations to reach are exact rounding ties and the symmetric-mode floor at -127. A tie occurs only when the product bits below the shift equal exactly one half. The floor is a clamp to -127 that must not spill to -128. Hitting either needs a chosen multiplier and shift, not random values. The stimulus therefore programs channels with a unit multiplier and a small shift, sends odd accumulators so that ties fall on both signs, and drives large negative values through the symmetric mode. A channel whose zero point is -128 pushes -1 below the signed floor. A random stream with consumer backpressure then checks result ordering and the stall-hold rule against the bench's own arithmetic model.

// File: rtl/requant_pkg.sv
package requant_pkg;

  typedef enum logic [1:0] {
    MODE_SASYM = 2'd0,
    MODE_UASYM = 2'd1,
    MODE_SYM   = 2'd2,
    MODE_SYMX  = 2'd3
  } qmode_e;

  // Load strobes the control hands to the datapath, one per stage
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
    logic v3;
  } stage_strobe_t;

endpackage

// File: rtl/requant_ctrl.sv
module requant_ctrl
  import requant_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic          outReady,
  output logic          inReady,
  output logic          outValid,
  output stage_strobe_t strobe
);

  localparam int STAGES = 3;

  logic [STAGES-1:0] stageVld;
  logic              advance;

  // The whole pipe moves unless the last stage holds an untaken result
  assign advance  = !(stageVld[STAGES-1] && !outReady);
  assign inReady  = advance;
  assign outValid = stageVld[STAGES-1];

  assign strobe.ld1 = advance && inValid;
  assign strobe.ld2 = advance && stageVld[0];
  assign strobe.ld3 = advance && stageVld[1];
  assign strobe.v3  = stageVld[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stageVld <= '0;
    end else if (advance) begin
      stageVld <= {stageVld[STAGES-2:0], inValid};
    end
  end

  // R2: an empty output register never blocks the input
  a_r2_no_block: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> inReady);

  // R1: a pending result is not dropped while the consumer stalls
  a_r1_keep_valid: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid);

endmodule

// File: rtl/requant_dp.sv
module requant_dp
  import requant_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int MULT_W  = 32,
  parameter int SHIFT_W = 6,
  parameter int OUT_W   = 8,
  parameter int CH_NUM  = 8,
  localparam int CH_W   = (CH_NUM > 1) ? $clog2(CH_NUM) : 1,
  localparam int DIFF_W = OUT_W + 2,
  localparam int DQ_W   = DIFF_W + MULT_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  stage_strobe_t       strobe,
  input  logic [ACC_W-1:0]    inAcc,
  input  logic [CH_W-1:0]     inChan,
  input  logic [1:0]          inMode,
  input  logic                cfgWe,
  input  logic [CH_W-1:0]     cfgChan,
  input  logic [MULT_W-1:0]   cfgMult,
  input  logic [SHIFT_W-1:0]  cfgShift,
  input  logic [OUT_W-1:0]    cfgZero,
  input  logic [OUT_W-1:0]    dqCode,
  input  logic [CH_W-1:0]     dqChan,
  input  logic [1:0]          dqMode,
  output logic [OUT_W-1:0]    outCode,
  output logic [CH_NUM-1:0]   satFlags,
  output logic [DQ_W-1:0]     dqValue
);

  localparam int PROD_W = ACC_W + MULT_W + 1;

  localparam logic signed [PROD_W-1:0] SIGNED_HI = PROD_W'(2**(OUT_W-1) - 1);
  localparam logic signed [PROD_W-1:0] SIGNED_LO = -(PROD_W'(2**(OUT_W-1)));
  localparam logic signed [PROD_W-1:0] UNSIG_HI  = PROD_W'(2**OUT_W - 1);
  localparam logic signed [PROD_W-1:0] UNSIG_LO  = '0;
  localparam logic signed [PROD_W-1:0] SYMM_LO   = -(PROD_W'(2**(OUT_W-1) - 1));

  // ---------------- channel configuration ----------------
  logic [MULT_W-1:0]  multTab  [CH_NUM];
  logic [SHIFT_W-1:0] shiftTab [CH_NUM];
  logic [OUT_W-1:0]   zeroTab  [CH_NUM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < CH_NUM; c++) begin
        multTab[c]  <= '0;
        shiftTab[c] <= '0;
        zeroTab[c]  <= '0;
      end
    end else if (cfgWe) begin
      multTab[cfgChan]  <= cfgMult;
      shiftTab[cfgChan] <= cfgShift;
      zeroTab[cfgChan]  <= cfgZero;
    end
  end

  // ---------------- stage 1: multiply ----------------
  logic signed [PROD_W-1:0] accExt, multExt, prodNext;
  logic signed [PROD_W-1:0] prod1;
  logic [SHIFT_W-1:0]       shift1;
  logic [OUT_W-1:0]         zero1;
  qmode_e                   mode1;
  logic [CH_W-1:0]          chan1;

  assign accExt   = {{(PROD_W-ACC_W){inAcc[ACC_W-1]}}, inAcc};
  assign multExt  = {{(PROD_W-MULT_W){1'b0}}, multTab[inChan]};
  assign prodNext = accExt * multExt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod1  <= '0;
      shift1 <= '0;
      zero1  <= '0;
      mode1  <= MODE_SASYM;
      chan1  <= '0;
    end else if (strobe.ld1) begin
      prod1  <= prodNext;
      shift1 <= shiftTab[inChan];
      zero1  <= zeroTab[inChan];
      mode1  <= qmode_e'(inMode);
      chan1  <= inChan;
    end
  end

  // ---------------- stage 2: round and shift ----------------
  logic [PROD_W-1:0]        mag2, half2, sum2, quo2;
  logic signed [PROD_W-1:0] rndNext;
  logic signed [PROD_W-1:0] rnd2;
  logic [OUT_W-1:0]         zero2;
  qmode_e                   mode2;
  logic [CH_W-1:0]          chan2;

  always_comb begin
    mag2 = prod1[PROD_W-1] ? PROD_W'(-prod1) : PROD_W'(prod1);
    if (shift1 == '0) begin
      half2 = '0;
    end else begin
      half2 = {{(PROD_W-1){1'b0}}, 1'b1} << (shift1 - 1'b1);
    end
    sum2 = mag2 + half2;
    quo2 = sum2 >> shift1;
    rndNext = prod1[PROD_W-1] ? -$signed(quo2) : $signed(quo2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rnd2  <= '0;
      zero2 <= '0;
      mode2 <= MODE_SASYM;
      chan2 <= '0;
    end else if (strobe.ld2) begin
      rnd2  <= rndNext;
      zero2 <= zero1;
      mode2 <= mode1;
      chan2 <= chan1;
    end
  end

  // ---------------- stage 3: zero point and clamp ----------------
  logic signed [PROD_W-1:0] zeroExt3, biased3, hiLim3, loLim3, clamp3;
  logic                     satNow3;
  qmode_e                   mode3;

  always_comb begin
    unique case (mode2)
      MODE_SASYM: begin
        zeroExt3 = {{(PROD_W-OUT_W){zero2[OUT_W-1]}}, zero2};
        hiLim3   = SIGNED_HI;
        loLim3   = SIGNED_LO;
      end
      MODE_UASYM: begin
        zeroExt3 = {{(PROD_W-OUT_W){1'b0}}, zero2};
        hiLim3   = UNSIG_HI;
        loLim3   = UNSIG_LO;
      end
      default: begin
        zeroExt3 = '0;
        hiLim3   = SIGNED_HI;
        loLim3   = SYMM_LO;
      end
    endcase
    biased3 = rnd2 + zeroExt3;
    if (biased3 > hiLim3) begin
      clamp3  = hiLim3;
      satNow3 = 1'b1;
    end else if (biased3 < loLim3) begin
      clamp3  = loLim3;
      satNow3 = 1'b1;
    end else begin
      clamp3  = biased3;
      satNow3 = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outCode <= '0;
      mode3   <= MODE_SASYM;
    end else if (strobe.ld3) begin
      outCode <= clamp3[OUT_W-1:0];
      mode3   <= mode2;
    end
  end

  // Sticky flags: a config write clears the channel, a clamp sets it
  generate
    for (genvar c = 0; c < CH_NUM; c++) begin : g_sat
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          satFlags[c] <= 1'b0;
        end else if (strobe.ld3 && satNow3 && (chan2 == CH_W'(c))) begin
          satFlags[c] <= 1'b1;
        end else if (cfgWe && (cfgChan == CH_W'(c))) begin
          satFlags[c] <= 1'b0;
        end
      end
    end
  endgenerate

  // ---------------- dequantize path ----------------
  logic signed [DIFF_W-1:0] dqCodeExt, dqZeroExt, dqDiff;
  logic signed [DQ_W-1:0]   dqDiffExt, dqMultExt;
  logic [OUT_W-1:0]         dqZ;

  assign dqZ = zeroTab[dqChan];

  always_comb begin
    unique case (qmode_e'(dqMode))
      MODE_UASYM: begin
        dqCodeExt = {{(DIFF_W-OUT_W){1'b0}}, dqCode};
        dqZeroExt = {{(DIFF_W-OUT_W){1'b0}}, dqZ};
      end
      MODE_SASYM: begin
        dqCodeExt = {{(DIFF_W-OUT_W){dqCode[OUT_W-1]}}, dqCode};
        dqZeroExt = {{(DIFF_W-OUT_W){dqZ[OUT_W-1]}}, dqZ};
      end
      default: begin
        dqCodeExt = {{(DIFF_W-OUT_W){dqCode[OUT_W-1]}}, dqCode};
        dqZeroExt = '0;
      end
    endcase
    dqDiff    = dqCodeExt - dqZeroExt;
    dqDiffExt = {{(DQ_W-DIFF_W){dqDiff[DIFF_W-1]}}, dqDiff};
    dqMultExt = {{(DQ_W-MULT_W){1'b0}}, multTab[dqChan]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dqValue <= '0;
    end else begin
      dqValue <= dqDiffExt * dqMultExt;
    end
  end

  // R6: symmetric results never reach the most negative code
  a_r6_sym_floor: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.v3 && (mode3 == MODE_SYM || mode3 == MODE_SYMX)
      |-> outCode != {1'b1, {(OUT_W-1){1'b0}}});

  // R7: a zero after rounding in signed mode lands on the zero point
  a_r7_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.ld3 && rnd2 == '0 && mode2 == MODE_SASYM |=> outCode == $past(zero2));

  // R9: flags only clear on a configuration write
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgWe |=> (satFlags & $past(satFlags)) == $past(satFlags));

endmodule

// File: rtl/requant_unit.sv
module requant_unit
  import requant_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int MULT_W  = 32,
  parameter int SHIFT_W = 6,
  parameter int OUT_W   = 8,
  parameter int CH_NUM  = 8,
  localparam int CH_W   = (CH_NUM > 1) ? $clog2(CH_NUM) : 1,
  localparam int DQ_W   = OUT_W + 2 + MULT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  output logic               inReady,
  input  logic [ACC_W-1:0]   inAcc,
  input  logic [CH_W-1:0]    inChan,
  input  logic [1:0]         inMode,
  output logic               outValid,
  input  logic               outReady,
  output logic [OUT_W-1:0]   outCode,
  output logic [CH_NUM-1:0]  satFlags,
  input  logic               cfgWe,
  input  logic [CH_W-1:0]    cfgChan,
  input  logic [MULT_W-1:0]  cfgMult,
  input  logic [SHIFT_W-1:0] cfgShift,
  input  logic [OUT_W-1:0]   cfgZero,
  input  logic [OUT_W-1:0]   dqCode,
  input  logic [CH_W-1:0]    dqChan,
  input  logic [1:0]         dqMode,
  output logic [DQ_W-1:0]    dqValue
);

  stage_strobe_t strobe;

  requant_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  requant_dp #(
    .ACC_W   (ACC_W),
    .MULT_W  (MULT_W),
    .SHIFT_W (SHIFT_W),
    .OUT_W   (OUT_W),
    .CH_NUM  (CH_NUM)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .inAcc    (inAcc),
    .inChan   (inChan),
    .inMode   (inMode),
    .cfgWe    (cfgWe),
    .cfgChan  (cfgChan),
    .cfgMult  (cfgMult),
    .cfgShift (cfgShift),
    .cfgZero  (cfgZero),
    .dqCode   (dqCode),
    .dqChan   (dqChan),
    .dqMode   (dqMode),
    .outCode  (outCode),
    .satFlags (satFlags),
    .dqValue  (dqValue)
  );

  // R1: a stalled result keeps its code
  a_r1_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outCode));

endmodule

// File: tb/requant_unit_bench.sv
module requant_unit_bench;

  localparam int CH_NUM = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inAcc = '0;
  logic [2:0]  inChan = '0;
  logic [1:0]  inMode = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [7:0]  outCode;
  logic [7:0]  satFlags;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgChan = '0;
  logic [31:0] cfgMult = '0;
  logic [5:0]  cfgShift = '0;
  logic [7:0]  cfgZero = '0;
  logic [7:0]  dqCode = '0;
  logic [2:0]  dqChan = '0;
  logic [1:0]  dqMode = '0;
  logic [42:0] dqValue;

  int checks = 0;
  int fails = 0;
  int stalls = 0;
  bit backPress = 1'b0;
  bit done = 1'b0;

  logic [31:0] shMult  [CH_NUM];
  logic [5:0]  shShift [CH_NUM];
  logic [7:0]  shZero  [CH_NUM];
  logic [7:0]  expSticky = '0;

  logic [7:0]  expQ [$];
  string       tagQ [$];

  always #4 clk = ~clk;

  requant_unit u_requant_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inAcc(inAcc), .inChan(inChan), .inMode(inMode), .outValid(outValid),
    .outReady(outReady), .outCode(outCode), .satFlags(satFlags),
    .cfgWe(cfgWe), .cfgChan(cfgChan), .cfgMult(cfgMult), .cfgShift(cfgShift),
    .cfgZero(cfgZero), .dqCode(dqCode), .dqChan(dqChan), .dqMode(dqMode),
    .dqValue(dqValue)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Requirement model for R3..R7
  function automatic void model(input logic [31:0] acc, input logic [31:0] m,
                                input logic [5:0] sh, input logic [7:0] z,
                                input logic [1:0] md, output logic [7:0] code,
                                output bit sat);
    logic signed [127:0] p, mag, r, zz, v, lo, hi, am, mm;
    bit neg;
    am = {{96{acc[31]}}, acc};
    mm = {96'b0, m};
    p = am * mm;
    neg = p < 0;
    mag = neg ? -p : p;
    if (sh == 0) r = mag;
    else r = (mag + (128'sd1 <<< (sh - 1))) >>> sh;
    if (neg) r = -r;
    if (md == 2'd1) begin
      zz = {120'b0, z}; lo = 0; hi = 255;
    end else if (md == 2'd0) begin
      zz = {{120{z[7]}}, z}; lo = -128; hi = 127;
    end else begin
      zz = 0; lo = -127; hi = 127;
    end
    v = r + zz;
    sat = 1'b0;
    if (v > hi) begin v = hi; sat = 1'b1; end
    else if (v < lo) begin v = lo; sat = 1'b1; end
    code = v[7:0];
  endfunction

  task automatic cfgWrite(input int ch, input logic [31:0] m, input logic [5:0] sh,
                          input logic [7:0] z);
    @(negedge clk);
    cfgWe = 1'b1; cfgChan = 3'(ch); cfgMult = m; cfgShift = sh; cfgZero = z;
    @(posedge clk);
    shMult[ch] = m; shShift[ch] = sh; shZero[ch] = z;
    expSticky[ch] = 1'b0;
    #1 cfgWe = 1'b0;
  endtask

  task automatic send(input logic [31:0] acc, input int ch, input logic [1:0] md,
                      input string tag);
    logic [7:0] e;
    bit s;
    @(negedge clk);
    inValid = 1'b1; inAcc = acc; inChan = 3'(ch); inMode = md;
    forever begin
      #3;
      if (inReady) break;
      stalls++;
      @(negedge clk);
    end
    @(posedge clk);
    model(acc, shMult[ch], shShift[ch], shZero[ch], md, e, s);
    expQ.push_back(e);
    tagQ.push_back(tag);
    if (s) expSticky[ch] = 1'b1;
    #1 inValid = 1'b0;
  endtask

  task automatic drain;
    int n = 0;
    while (expQ.size() != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic dqCheck(input logic [7:0] code, input int ch, input logic [1:0] md);
    longint c, z, exp;
    @(negedge clk);
    dqCode = code; dqChan = 3'(ch); dqMode = md;
    @(negedge clk);
    if (md == 2'd1) begin c = code; z = shZero[ch]; end
    else begin
      c = longint'($signed(code));
      z = (md == 2'd0) ? longint'($signed(shZero[ch])) : 0;
    end
    exp = (c - z) * longint'(shMult[ch]);
    check(longint'($signed(dqValue)) == exp, "R10 dequant", longint'($signed(dqValue)), exp);
  endtask

  // Consumer readiness, changed only at falling edges
  initial begin
    forever begin
      @(negedge clk);
      outReady = backPress ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // Monitor: looks just before each rising edge
  initial begin
    logic [7:0] heldCode;
    logic [7:0] e;
    string t;
    bit wasStalled = 1'b0;
    forever begin
      @(negedge clk);
      #3;
      if (rst_n) begin
        if (wasStalled) begin
          check(outValid && outCode == heldCode, "R1 stall hold",
                longint'(outCode), longint'(heldCode));
        end
        wasStalled = outValid && !outReady;
        heldCode = outCode;
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R2 unexpected output", longint'(outCode), -1);
          end else begin
            e = expQ.pop_front();
            t = tagQ.pop_front();
            check(outCode == e, t, longint'(outCode), longint'(e));
          end
        end
      end
    end
  end

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      finishRun();
    end
  end

  initial begin
    int n;
    for (int c = 0; c < CH_NUM; c++) begin
      shMult[c] = '0; shShift[c] = '0; shZero[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    // R11 reset state
    check(outValid == 1'b0, "R11 outValid", longint'(outValid), 0);
    check(inReady == 1'b1, "R11 inReady", longint'(inReady), 1);
    check(satFlags == 8'h00, "R11 satFlags", longint'(satFlags), 0);
    dqCheck(8'h05, 3, 2'd0);   // R11 zero multiplier gives zero

    // R8 per-channel configuration
    cfgWrite(0, 32'd1, 6'd1, 8'h00);
    cfgWrite(1, 32'd1, 6'd2, 8'd10);
    cfgWrite(2, 32'd3, 6'd0, 8'hFB);
    cfgWrite(3, 32'h8000_0000, 6'd40, 8'h00);
    cfgWrite(4, 32'd1000, 6'd4, 8'd100);
    cfgWrite(5, 32'd1, 6'd0, 8'd50);
    cfgWrite(6, 32'hFFFF_FFFF, 6'd63, 8'h00);
    cfgWrite(7, 32'd1, 6'd0, 8'h80);

    // R7 zero input gives the zero point in every mode
    for (int c = 0; c < CH_NUM; c++) begin
      send(32'd0, c, 2'd0, "R7 zero mode0");
      send(32'd0, c, 2'd1, "R7 zero mode1");
      send(32'd0, c, 2'd2, "R7 zero mode2");
    end
    drain();

    // R3 rounding ties and shifts
    send(32'd3, 0, 2'd0, "R3 tie +1.5");
    send(-32'sd3, 0, 2'd0, "R3 tie -1.5");
    send(32'd1, 0, 2'd0, "R3 tie +0.5");
    send(-32'sd1, 0, 2'd0, "R3 tie -0.5");
    send(32'd2, 0, 2'd0, "R3 exact");
    send(32'd6, 1, 2'd0, "R3 zp add tie");
    send(-32'sd6, 1, 2'd0, "R3 zp add neg tie");
    send(32'd5, 1, 2'd0, "R3 round down");
    send(32'd1000, 3, 2'd0, "R3 wide mult");
    send(-32'sd7, 2, 2'd0, "R8 ch2 scale");
    send(32'h7FFF_FFFF, 6, 2'd0, "R3 max product");
    send(32'h8000_0000, 6, 2'd0, "R3 min product");
    drain();
    check(satFlags == expSticky, "R9 flags after rounding", longint'(satFlags),
          longint'(expSticky));

    // R4 signed clamp after zero point
    send(32'd1000, 0, 2'd0, "R4 clamp high");
    send(-32'sd1, 7, 2'd0, "R4 clamp low after zp");
    send(32'd127, 7, 2'd0, "R4 within after zp");
    // R5 unsigned
    send(32'd5, 4, 2'd1, "R5 clamp 255");
    send(-32'sd1, 4, 2'd1, "R5 neg tie inside");
    send(-32'sd2, 4, 2'd1, "R5 clamp 0");
    // R6 symmetric
    send(-32'sd1000, 0, 2'd2, "R6 floor -127");
    send(32'd1000, 0, 2'd3, "R6 ceiling 127");
    send(32'd20, 5, 2'd2, "R6 zero point ignored");
    send(-32'sd128, 5, 2'd3, "R6 -128 clamps");
    drain();
    check(satFlags == expSticky, "R9 sticky set", longint'(satFlags), longint'(expSticky));

    // R9 clear by config write; R8 new config used afterwards
    cfgWrite(0, 32'd4, 6'd0, 8'd1);
    repeat (2) @(negedge clk);
    #3;
    check(satFlags == expSticky, "R9 cleared by write", longint'(satFlags),
          longint'(expSticky));
    send(32'd5, 0, 2'd0, "R8 new config applied");
    drain();

    // R1 latency
    send(32'd9, 0, 2'd0, "R1 single item");
    n = 0;
    do begin
      @(negedge clk);
      #3;
      n++;
    end while (!outValid && n < 8);
    check(n == 3, "R1 latency", n, 3);
    drain();

    // R2 back-to-back stream
    stalls = 0;
    for (int i = 0; i < 40; i++) begin
      send(32'(i * 37 - 700), i % CH_NUM, 2'(i % 3), "R2 stream order");
    end
    check(stalls == 0, "R2 no input stall", stalls, 0);
    drain();

    // R1/R3 random stream under backpressure
    backPress = 1'b1;
    for (int i = 0; i < 300; i++) begin
      send($urandom(), $urandom_range(0, CH_NUM - 1), 2'($urandom_range(0, 3)),
           "R1 random backpressure");
    end
    drain();
    backPress = 1'b0;
    drain();
    check(satFlags == expSticky, "R9 flags after random", longint'(satFlags),
          longint'(expSticky));

    // R10 dequantize
    dqCheck(8'h05, 2, 2'd0);
    dqCheck(8'hFB, 2, 2'd1);
    dqCheck(8'h00, 4, 2'd1);
    dqCheck(8'h81, 5, 2'd2);
    dqCheck(8'hFF, 4, 2'd1);
    dqCheck(8'h7F, 6, 2'd3);

    done = 1'b1;
    finishRun();
  end

endmodule